// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block keeps four 16-bit segment base registers: code, stack, data and extra. Each register marks where a 64 KB window starts inside a 1 MB byte space. For every memory access it chooses one segment, either from fixed default rules or from an explicit override. It then forms a 20-bit physical address by shifting the segment left by four bits and adding a 16-bit offset. It also reports which segment it used as a 2-bit code for the bus status lines.

The caller supplies four inputs:
- the kind of access: instruction fetch, stack access, ordinary data or string destination;
- a flag that says whether the effective address was based on the stack or frame pointer;
- an optional override;
- the offset.

The address and the segment code are combinational in these inputs. A segment can change in two ways. A general load port writes the stack, data and extra segments. A separate far-transfer port is the only path that changes the code segment.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset the code segment holds FFFFh, and the stack, data and extra segments hold 0000h.
- R2: An access of kind 0 (instruction fetch) always uses the code segment, whatever the override inputs are.
- R3: An access of kind 1 (stack access) uses the stack segment when no override is given.
- R4: An access of kind 2 (ordinary data) uses the stack segment when the base flag is 1, and the data segment when the flag is 0, provided no override is given.
- R5: An access of kind 3 (string destination) always uses the extra segment, whatever the override inputs are.
- R6: For kinds 1 and 2, an asserted override enable selects the segment named by the override select code, and this replaces the default.
- R7: The physical address equals (segment × 16 + offset) modulo 2^20. It follows the inputs in the same cycle, and a sum of 2^20 or more wraps around.
- R8: The segment code output identifies the segment actually used: 00 = extra, 01 = stack, 10 = code, 11 = data. The override select and the load select use the same encoding.
- R9: A general load writes the selected segment and takes effect after the next rising clock edge. A general load that selects code 10 (code segment) has no effect.
- R10: A far-transfer load writes the code segment, and takes effect after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_kind | input | 2 | Access kind: 0 fetch, 1 stack, 2 data, 3 string destination |
| stk_base | input | 1 | Effective address formed from the stack or frame pointer |
| ovr_en | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment code |
| offset | input | 16 | Offset within the segment |
| seg_we | input | 1 | General segment load strobe |
| seg_wsel | input | 2 | Segment code to load |
| seg_wdata | input | 16 | Value to load |
| far_we | input | 1 | Far-transfer code segment load strobe |
| far_cs | input | 16 | New code segment value |
| phys_addr | output | 20 | Physical address |
| seg_code | output | 2 | Code of the segment used |

## Verification
The segment registers sit directly behind a combinational adder, so any wrong register content shows up at once on phys_addr. It appears in the first cycle after the faulty load that selects that segment, as an error exactly sixteen times the register difference. A wrong selection rule shows up on seg_code in the same cycle as the access. The sweeps cover every combination of kind, base flag and override for several segment contents, including a wrapping sum. Because of that, every register and every route through the rules is observed within a few cycles of its last change.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W  = 16,
  parameter int SHIFT  = 4,
  parameter logic [SEG_W-1:0] CS_RST = '1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             acc_kind,
  input  logic                   stk_base,
  input  logic                   ovr_en,
  input  logic [1:0]             ovr_sel,
  input  logic [SEG_W-1:0]       offset,
  input  logic                   seg_we,
  input  logic [1:0]             seg_wsel,
  input  logic [SEG_W-1:0]       seg_wdata,
  input  logic                   far_we,
  input  logic [SEG_W-1:0]       far_cs,
  output logic [SEG_W+SHIFT-1:0] phys_addr,
  output logic [1:0]             seg_code
);
  localparam int ADDR_W = SEG_W + SHIFT;
  localparam logic [1:0] SEG_ES = 2'd0;
  localparam logic [1:0] SEG_SS = 2'd1;
  localparam logic [1:0] SEG_CS = 2'd2;
  localparam logic [1:0] SEG_DS = 2'd3;
  localparam logic [1:0] K_FETCH = 2'd0;
  localparam logic [1:0] K_STACK = 2'd1;
  localparam logic [1:0] K_DATA  = 2'd2;

  logic [SEG_W-1:0] seg_q [4];

  for (genvar g = 0; g < 4; g++) begin : g_seg
    localparam logic [SEG_W-1:0] RST_V = (g == int'(SEG_CS)) ? CS_RST : '0;
    if (g == int'(SEG_CS)) begin : g_code
      always_ff @(posedge clk) begin
        if (!rst_n)      seg_q[g] <= RST_V;
        else if (far_we) seg_q[g] <= far_cs;
      end
    end else begin : g_gen
      always_ff @(posedge clk) begin
        if (!rst_n)                                 seg_q[g] <= RST_V;
        else if (seg_we && seg_wsel == 2'(g))       seg_q[g] <= seg_wdata;
      end
    end
  end

  logic [1:0] sel;

  always_comb begin
    case (acc_kind)
      K_FETCH: sel = SEG_CS;
      K_STACK: sel = ovr_en ? ovr_sel : SEG_SS;
      K_DATA:  sel = ovr_en ? ovr_sel : (stk_base ? SEG_SS : SEG_DS);
      default: sel = SEG_ES;
    endcase
  end

  assign seg_code  = sel;
  assign phys_addr = {seg_q[sel], {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, offset};

  logic unused_ok;
  assign unused_ok = &{1'b0, ADDR_W[0]};
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  acc_kind,
  input logic        stk_base,
  input logic        ovr_en,
  input logic [1:0]  ovr_sel,
  input logic [15:0] offset,
  input logic        far_we,
  input logic [15:0] far_cs,
  input logic [19:0] phys_addr,
  input logic [1:0]  seg_code
);
  // R2
  fetch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_kind == 2'd0 |-> seg_code == 2'b10);
  // R5
  strdst_extra_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_kind == 2'd3 |-> seg_code == 2'b00);
  // R3
  stack_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 2'd1 && !ovr_en) |-> seg_code == 2'b01);
  // R4
  data_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 2'd2 && !ovr_en) |-> seg_code == (stk_base ? 2'b01 : 2'b11));
  // R6
  override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_kind == 2'd1 || acc_kind == 2'd2) && ovr_en) |-> seg_code == ovr_sel);
  // R9
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 2'd0 && $past(acc_kind) == 2'd0 && !$past(far_we) && $stable(offset))
      |-> $stable(phys_addr));
  // R10
  far_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    far_we |=> (acc_kind != 2'd0 ||
                phys_addr == ({$past(far_cs), 4'h0} + {4'h0, offset})));
endmodule

bind seg_addr_gen seg_addr_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_kind(acc_kind), .stk_base(stk_base),
  .ovr_en(ovr_en), .ovr_sel(ovr_sel), .offset(offset), .far_we(far_we),
  .far_cs(far_cs), .phys_addr(phys_addr), .seg_code(seg_code)
);

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  acc_kind = '0;
  logic        stk_base = 1'b0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_sel = '0;
  logic [15:0] offset = '0;
  logic        seg_we = 1'b0;
  logic [1:0]  seg_wsel = '0;
  logic [15:0] seg_wdata = '0;
  logic        far_we = 1'b0;
  logic [15:0] far_cs = '0;
  logic [19:0] phys_addr;
  logic [1:0]  seg_code;

  int vecs = 0;
  int bad = 0;
  logic [15:0] mdl [4];

  always #2 clk = ~clk;

  seg_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .acc_kind(acc_kind), .stk_base(stk_base),
    .ovr_en(ovr_en), .ovr_sel(ovr_sel), .offset(offset), .seg_we(seg_we),
    .seg_wsel(seg_wsel), .seg_wdata(seg_wdata), .far_we(far_we),
    .far_cs(far_cs), .phys_addr(phys_addr), .seg_code(seg_code)
  );

  function automatic logic [1:0] pick(input logic [1:0] k, input logic b,
                                      input logic oe, input logic [1:0] os);
    if (k == 2'd0) return 2'b10;
    if (k == 2'd3) return 2'b00;
    if (oe) return os;
    if (k == 2'd1 || b) return 2'b01;
    return 2'b11;
  endfunction

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] k, input logic b, input logic oe,
                       input logic [1:0] os, input logic [15:0] off, input string req);
    logic [1:0]  c;
    logic [19:0] e;
    @(negedge clk);
    acc_kind = k; stk_base = b; ovr_en = oe; ovr_sel = os; offset = off;
    #1;
    c = pick(k, b, oe, os);
    e = {mdl[c], 4'h0} + {4'h0, off};
    chk({req, " R8 code"}, {18'd0, seg_code}, {18'd0, c});
    chk({req, " R7 addr"}, phys_addr, e);
  endtask

  task automatic gload(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk);
    seg_we = 1'b1; seg_wsel = s; seg_wdata = v;
    if (s != 2'b10) mdl[s] = v;
    @(negedge clk);
    seg_we = 1'b0;
  endtask

  task automatic fload(input logic [15:0] v);
    @(negedge clk);
    far_we = 1'b1; far_cs = v; mdl[2] = v;
    @(negedge clk);
    far_we = 1'b0;
  endtask

  task automatic sweep(input logic [15:0] off);
    for (int k = 0; k < 4; k++)
      for (int b = 0; b < 2; b++)
        for (int oe = 0; oe < 2; oe++)
          for (int os = 0; os < 4; os++)
            apply(2'(k), 1'(b), 1'(oe), 2'(os), off,
                  k == 0 ? "R2" : k == 3 ? "R5" : oe == 1 ? "R6" : k == 1 ? "R3" : "R4");
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    mdl[0] = 16'h0000; mdl[1] = 16'h0000; mdl[2] = 16'hFFFF; mdl[3] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset contents seen through each default route
    apply(2'd0, 1'b0, 1'b0, 2'd0, 16'h0000, "R1");
    apply(2'd1, 1'b0, 1'b0, 2'd0, 16'h0000, "R1");
    apply(2'd2, 1'b0, 1'b0, 2'd0, 16'h0000, "R1");
    apply(2'd3, 1'b0, 1'b0, 2'd0, 16'h0000, "R1");
    // R9 loads, including an ignored load of the code segment
    gload(2'd0, 16'h1234);
    gload(2'd1, 16'h8000);
    gload(2'd3, 16'hFFFF);
    gload(2'd2, 16'h4321);
    apply(2'd0, 1'b0, 1'b0, 2'd0, 16'h0010, "R9");
    foreach (mdl[i]) apply(2'd2, 1'b0, 1'b1, 2'(i), 16'h0001, "R9");
    sweep(16'h0000);
    sweep(16'h000F);
    sweep(16'h8001);
    sweep(16'hFFFF);
    // R10 far transfer
    fload(16'hABCD);
    apply(2'd0, 1'b0, 1'b1, 2'd3, 16'h0003, "R10");
    sweep(16'h5A5A);
    gload(2'd0, 16'hF000);
    gload(2'd1, 16'h0FFF);
    gload(2'd3, 16'h00FF);
    fload(16'hFFF1);
    for (int j = 0; j < 16; j++) sweep(16'((j * 16'h1111) ^ 16'h00F0));
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule